// File: doc/BRIEF.md
# Wake-Execute-Sleep Transaction Sequencer

This block runs the host side of a single exchange with a coprocessor that spends most of its life asleep on an I2C bus. A request carries the bus clock rate in kHz, the length of a command frame that is already prepared elsewhere, the execution time of that command in milliseconds, and the expected response length. The sequencer issues a run of zero bytes long enough to hold the data line low for the wake time. It waits for the part to come up and reads a four-byte status group. It then sends the frame, waits out the execution time, reads the response and finally sends one sleep byte. The outcome is reported as a result byte on a one-cycle done pulse.

The sequencer does not move bytes itself. It commands a byte-level I2C master through a start pulse, an operation selector and a byte count. It watches that master's done and error flags, and it observes received bytes as they stream past so it can decode the leading length byte and code byte of a status group. All waits are counted in milliseconds from a tick derived from the clock-frequency parameter. Requests the part could not serve are refused before the bus is touched: a bus rate out of range, or waits that would overrun the part's wake watchdog window.

Top module: `wake_cmd_sleep_seq`

## Requirements
- R1: An accepted request produces, in order, these bus operations, each announced by a one-cycle `bus_start` with `bus_sel`/`bus_len`: wake write (sel 00), status read of 4 bytes (sel 11), command write of `frame_len` bytes (sel 01), response read of `resp_len` bytes (sel 11), sleep write of exactly 1 byte (sel 10).
- R2: The wake write length in bytes is ceil(ceil(TWLO_US * bus_khz / 1000) / 8). With TWLO_US = 60 this gives 1 byte at 100 kHz, 3 at 400 kHz and 8 at 1000 kHz.
- R3: A request with `bus_khz` of 0 or above MAX_KHZ (1000) is refused. No bus operation is issued, and `done` pulses two cycles after the start cycle with result 0xB1.
- R4: The error flag returned for the wake write is ignored, and the sequence continues as normal.
- R5: The status read starts WAKE_WAIT_MS milliseconds after the wake write completes. The response read starts `exec_ms` milliseconds after the command write completes. One millisecond is CLK_HZ/1000 cycles, and up to 6 extra cycles of pipeline slack are allowed.
- R6: A status group (first received byte = length, second = code) signals a fault only when its length byte equals 4 and its code is one of 0x01, 0x03, 0x05, 0x0F, 0xEE or 0xFF. Codes 0x00 (no error) and 0x11 (awake) and all other codes count as success, as does any group whose length byte is not 4.
- R7: A fault in the status group read after wake ends the request at once with that code as the result. No command, response or sleep operation follows.
- R8: A fault in the response group becomes the result, but the sleep byte is still sent first.
- R9: An error flag on the status read, the command write, the response read or the sleep write ends the request at once with result 0xB0. No further bus operation is issued.
- R10: A request whose `exec_ms` + WAKE_WAIT_MS is not below WDT_MS is refused. No bus operation is issued, and `done` pulses two cycles after the start cycle with result 0xB2.
- R11: `busy` rises the cycle after an accepted start and falls in the cycle `done` pulses. `done` lasts one cycle, bus operations occur only while busy, and `start` while busy has no effect.
- R12: After reset, `busy`, `done` and `bus_start` are low and `result` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (taken only when idle) |
| bus_khz | input | KHZ_W | Bus clock rate in kHz |
| frame_len | input | LEN_W | Command frame length in bytes |
| exec_ms | input | MS_W | Command execution wait in ms |
| resp_len | input | LEN_W | Response length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | 0x00 success, device fault code, 0xB0 bus error, 0xB1 bad rate, 0xB2 over budget |
| bus_start | output | 1 | One-cycle request to the I2C master |
| bus_sel | output | 2 | 00 wake zeros, 01 command frame, 10 sleep byte, 11 read |
| bus_len | output | LEN_W | Byte count of the operation |
| bus_done | input | 1 | Master finished the operation |
| bus_err | input | 1 | Master reports failure, valid with bus_done |
| bus_rx_valid | input | 1 | Received byte strobe |
| bus_rx_data | input | 8 | Received byte |

## Verification
A wrong state step in the controller shows up on the very next `bus_start` as an operation with the wrong selector or length, or as an operation that should never have been issued after a fault. A stalled wait counter or tick shows up as a status or response read that arrives outside its millisecond window, or as no `done` at all. A mistake in the status decode appears only at the `done` pulse that closes the request, as a wrong result byte. A latched fault that leaks into the next request shows up as a wrong result there.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_WAKE  = 4'd1,
        ST_WWAIT = 4'd2,
        ST_SREAD = 4'd3,
        ST_CMD   = 4'd4,
        ST_EWAIT = 4'd5,
        ST_RREAD = 4'd6,
        ST_SLEEP = 4'd7,
        ST_FIN   = 4'd8
    } seq_st_e;

    typedef enum logic [1:0] {
        SEL_WAKE  = 2'b00,
        SEL_CMD   = 2'b01,
        SEL_SLEEP = 2'b10,
        SEL_READ  = 2'b11
    } bus_sel_e;

    localparam logic [7:0] GRP_LEN    = 8'd4;
    localparam logic [7:0] RES_OK     = 8'h00;
    localparam logic [7:0] RES_BUS    = 8'hB0;
    localparam logic [7:0] RES_RATE   = 8'hB1;
    localparam logic [7:0] RES_BUDGET = 8'hB2;

    // Device codes that denote a fault; 0x00 and 0x11 are success.
    function automatic logic code_is_fault(input logic [7:0] c);
        case (c)
            8'h01, 8'h03, 8'h05, 8'h0F, 8'hEE, 8'hFF: code_is_fault = 1'b1;
            default:                                  code_is_fault = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wcs_tick.sv
module wcs_tick #(
    parameter int TICK_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CNT_W'(TICK_CYC - 1));

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wcs_wake_len.sv
module wcs_wake_len #(
    parameter int KHZ_W   = 11,
    parameter int LEN_W   = 8,
    parameter int TWLO_US = 60,
    parameter int MAX_KHZ = 1000
) (
    input  logic [KHZ_W-1:0] khz,
    output logic [LEN_W-1:0] nbytes,
    output logic             rate_ok
);
    // bits = ceil(TWLO_US * khz / 1000); bytes = ceil(bits / 8)
    assign nbytes  = LEN_W'((((32'(TWLO_US) * 32'(khz) + 32'd999) / 32'd1000) + 32'd7) / 32'd8);
    assign rate_ok = (khz != '0) && (32'(khz) <= 32'(MAX_KHZ));
endmodule

// File: rtl/wcs_status_dec.sv
module wcs_status_dec
    import wcs_pkg::*;
(
    input  logic [7:0] len_b,
    input  logic [7:0] code_b,
    output logic [7:0] fault
);
    assign fault = ((len_b == GRP_LEN) && code_is_fault(code_b)) ? code_b : RES_OK;
endmodule

// File: rtl/wake_cmd_sleep_seq.sv
module wake_cmd_sleep_seq
    import wcs_pkg::*;
#(
    parameter int CLK_HZ       = 50000000,
    parameter int TWLO_US      = 60,
    parameter int MAX_KHZ      = 1000,
    parameter int WAKE_WAIT_MS = 1,
    parameter int WDT_MS       = 1300,
    parameter int KHZ_W        = 11,
    parameter int LEN_W        = 8,
    parameter int MS_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KHZ_W-1:0] bus_khz,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [MS_W-1:0]  exec_ms,
    input  logic [LEN_W-1:0] resp_len,
    output logic             busy,
    output logic             done,
    output logic [7:0]       result,
    output logic             bus_start,
    output logic [1:0]       bus_sel,
    output logic [LEN_W-1:0] bus_len,
    input  logic             bus_done,
    input  logic             bus_err,
    input  logic             bus_rx_valid,
    input  logic [7:0]       bus_rx_data
);
    localparam int TICK_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    typedef struct packed {
        seq_st_e          st;
        logic             issued;
        logic [1:0]       rx_idx;
        logic [7:0]       b0;
        logic [7:0]       b1;
        logic [LEN_W-1:0] wake_len;
        logic [LEN_W-1:0] frame_len;
        logic [LEN_W-1:0] resp_len;
        logic [MS_W-1:0]  exec_ms;
        logic [MS_W-1:0]  ms_left;
        logic             bus_start;
        logic [1:0]       sel;
        logic [LEN_W-1:0] blen;
        logic             done;
        logic [7:0]       result;
    } seq_t;

    seq_t d, q;

    logic             tick, tick_clr;
    logic [LEN_W-1:0] wake_bytes;
    logic             rate_ok;
    logic [7:0]       fault;
    logic             is_bus;
    logic [1:0]       op_sel;
    logic [LEN_W-1:0] op_len;
    logic             op_end;
    logic             over_budget;

    wcs_tick #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    wcs_wake_len #(
        .KHZ_W(KHZ_W), .LEN_W(LEN_W), .TWLO_US(TWLO_US), .MAX_KHZ(MAX_KHZ)
    ) u_wlen (
        .khz(bus_khz), .nbytes(wake_bytes), .rate_ok(rate_ok)
    );

    wcs_status_dec u_dec (
        .len_b(q.b0), .code_b(q.b1), .fault(fault)
    );

    assign tick_clr    = !((q.st == ST_WWAIT) || (q.st == ST_EWAIT));
    assign op_end      = q.issued && bus_done;
    assign over_budget = (32'(exec_ms) + 32'(WAKE_WAIT_MS)) >= 32'(WDT_MS);

    always_comb begin
        d      = q;
        d.bus_start = 1'b0;
        d.done      = 1'b0;

        // Operation that the current state puts on the bus.
        is_bus = 1'b1;
        op_sel = SEL_WAKE;
        op_len = q.wake_len;
        case (q.st)
            ST_WAKE:  begin op_sel = SEL_WAKE;  op_len = q.wake_len;  end
            ST_SREAD: begin op_sel = SEL_READ;  op_len = LEN_W'(4);   end
            ST_CMD:   begin op_sel = SEL_CMD;   op_len = q.frame_len; end
            ST_RREAD: begin op_sel = SEL_READ;  op_len = q.resp_len;  end
            ST_SLEEP: begin op_sel = SEL_SLEEP; op_len = LEN_W'(1);   end
            default:  is_bus = 1'b0;
        endcase

        if (is_bus && !q.issued) begin
            d.issued    = 1'b1;
            d.bus_start = 1'b1;
            d.sel       = op_sel;
            d.blen      = op_len;
            d.rx_idx    = 2'd0;
            d.b0        = 8'h00;
            d.b1        = 8'h00;
        end

        // Capture the first two bytes of any read.
        if (bus_rx_valid && q.issued && ((q.st == ST_SREAD) || (q.st == ST_RREAD))) begin
            if (q.rx_idx == 2'd0) d.b0 = bus_rx_data;
            if (q.rx_idx == 2'd1) d.b1 = bus_rx_data;
            if (q.rx_idx != 2'd2) d.rx_idx = q.rx_idx + 2'd1;
        end

        if (op_end) d.issued = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.wake_len  = wake_bytes;
                    d.frame_len = frame_len;
                    d.resp_len  = resp_len;
                    d.exec_ms   = exec_ms;
                    d.result    = RES_OK;
                    d.issued    = 1'b0;
                    if (!rate_ok) begin
                        d.result = RES_RATE;
                        d.st     = ST_FIN;
                    end else if (over_budget) begin
                        d.result = RES_BUDGET;
                        d.st     = ST_FIN;
                    end else begin
                        d.st = ST_WAKE;
                    end
                end
            end
            ST_WAKE: begin
                if (op_end) begin
                    d.st      = ST_WWAIT;
                    d.ms_left = MS_W'(WAKE_WAIT_MS);
                end
            end
            ST_WWAIT, ST_EWAIT: begin
                if (q.ms_left == '0)
                    d.st = (q.st == ST_WWAIT) ? ST_SREAD : ST_RREAD;
                else if (tick)
                    d.ms_left = q.ms_left - 1'b1;
            end
            ST_SREAD: begin
                if (op_end) begin
                    if (bus_err) begin
                        d.result = RES_BUS;
                        d.st     = ST_FIN;
                    end else if (fault != RES_OK) begin
                        d.result = fault;
                        d.st     = ST_FIN;
                    end else begin
                        d.st = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (op_end) begin
                    if (bus_err) begin
                        d.result = RES_BUS;
                        d.st     = ST_FIN;
                    end else begin
                        d.st      = ST_EWAIT;
                        d.ms_left = q.exec_ms;
                    end
                end
            end
            ST_RREAD: begin
                if (op_end) begin
                    if (bus_err) begin
                        d.result = RES_BUS;
                        d.st     = ST_FIN;
                    end else begin
                        d.result = fault;
                        d.st     = ST_SLEEP;
                    end
                end
            end
            ST_SLEEP: begin
                if (op_end) begin
                    if (bus_err) d.result = RES_BUS;
                    d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign result    = q.result;
    assign bus_start = q.bus_start;
    assign bus_sel   = q.sel;
    assign bus_len   = q.blen;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker
    import wcs_pkg::*;
#(
    parameter int MAX_KHZ      = 1000,
    parameter int WAKE_WAIT_MS = 1,
    parameter int WDT_MS       = 1300,
    parameter int KHZ_W        = 11,
    parameter int LEN_W        = 8,
    parameter int MS_W         = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [KHZ_W-1:0] bus_khz,
    input logic [MS_W-1:0]  exec_ms,
    input logic             busy,
    input logic             done,
    input logic [7:0]       result,
    input logic             bus_start,
    input logic [1:0]       bus_sel,
    input logic [LEN_W-1:0] bus_len
);
    logic rate_bad, budget_bad;
    assign rate_bad   = (bus_khz == '0) || (32'(bus_khz) > 32'(MAX_KHZ));
    assign budget_bad = (32'(exec_ms) + 32'(WAKE_WAIT_MS)) >= 32'(WDT_MS);

    p_sleep_one_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_sel == SEL_SLEEP) |-> (bus_len == LEN_W'(1)));

    p_rate_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rate_bad) |=> ##1 (done && result == RES_RATE));

    p_rate_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rate_bad) |=> !bus_start);

    p_budget_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !rate_bad && budget_bad) |=> ##1 (done && result == RES_BUDGET));

    p_busy_falls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_bus_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> busy);
endmodule

bind wake_cmd_sleep_seq wcs_checker #(
    .MAX_KHZ(MAX_KHZ), .WAKE_WAIT_MS(WAKE_WAIT_MS), .WDT_MS(WDT_MS),
    .KHZ_W(KHZ_W), .LEN_W(LEN_W), .MS_W(MS_W)
) u_wcs_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_khz(bus_khz),
    .exec_ms(exec_ms), .busy(busy), .done(done), .result(result),
    .bus_start(bus_start), .bus_sel(bus_sel), .bus_len(bus_len)
);

// File: tb/tb_wake_cmd_sleep_seq.sv
module tb_wake_cmd_sleep_seq;
    localparam int CLK_HZ = 20000;
    localparam int TICK   = 20;
    localparam int WAKEMS = 1;
    localparam int WDT    = 20;
    localparam int TWLO   = 60;
    localparam int MAXK   = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] bus_khz = 11'd100;
    logic [7:0]  frame_len = 8'd7;
    logic [10:0] exec_ms = 11'd2;
    logic [7:0]  resp_len = 8'd35;
    logic        busy, done, bus_start;
    logic [7:0]  result;
    logic [1:0]  bus_sel;
    logic [7:0]  bus_len;
    logic        bus_done = 1'b0, bus_err = 1'b0, bus_rx_valid = 1'b0;
    logic [7:0]  bus_rx_data = 8'h00;

    always #10 clk = ~clk;

    wake_cmd_sleep_seq #(
        .CLK_HZ(CLK_HZ), .TWLO_US(TWLO), .MAX_KHZ(MAXK),
        .WAKE_WAIT_MS(WAKEMS), .WDT_MS(WDT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_khz(bus_khz),
        .frame_len(frame_len), .exec_ms(exec_ms), .resp_len(resp_len),
        .busy(busy), .done(done), .result(result), .bus_start(bus_start),
        .bus_sel(bus_sel), .bus_len(bus_len), .bus_done(bus_done),
        .bus_err(bus_err), .bus_rx_valid(bus_rx_valid), .bus_rx_data(bus_rx_data)
    );

    int errs = 0, checks = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int sel; int len; } op_t;
    op_t expq[$];

    int   err_op = -1;
    logic [7:0] st_b0 = 8'd4, st_b1 = 8'h11, rs_b0 = 8'd35, rs_b1 = 8'h00;
    int   op_no = 0, rd_no = 0;
    int   t_start[5], t_done[5];
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int wake_bytes(input int khz);
        return ((TWLO * khz + 999) / 1000 + 7) / 8;
    endfunction

    // Bus model and monitor: pops the expected operation for each request.
    int m_sel, m_len, m_idx, m_rd;
    op_t m_exp;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_start) begin
                m_sel = int'(bus_sel);
                m_len = int'(bus_len);
                m_idx = op_no;
                op_no++;
                if (m_idx < 5) t_start[m_idx] = cyc;
                if (expq.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected bus op sel", m_sel, -1);
                end else begin
                    m_exp = expq.pop_front();
                    chk(m_sel == m_exp.sel, cur_req, "op sel", m_sel, m_exp.sel);
                    chk(m_len == m_exp.len, cur_req, "op len", m_len, m_exp.len);
                end
                repeat (2) @(negedge clk);
                if (m_sel == 3) begin
                    m_rd = rd_no;
                    rd_no++;
                    for (int i = 0; i < m_len; i++) begin
                        bus_rx_valid = 1'b1;
                        if (i == 0)      bus_rx_data = (m_rd == 0) ? st_b0 : rs_b0;
                        else if (i == 1) bus_rx_data = (m_rd == 0) ? st_b1 : rs_b1;
                        else             bus_rx_data = 8'(i);
                        @(negedge clk);
                    end
                    bus_rx_valid = 1'b0;
                end
                bus_done = 1'b1;
                bus_err  = (m_idx == err_op);
                if (m_idx < 5) t_done[m_idx] = cyc;
                @(negedge clk);
                bus_done = 1'b0;
                bus_err  = 1'b0;
            end
        end
    end

    task automatic push_op(input int s, input int l);
        op_t o;
        o.sel = s;
        o.len = l;
        expq.push_back(o);
    endtask

    task automatic run_txn(input string req, input int khz, input int flen,
                           input int ems, input int rlen, input int nops,
                           input logic [7:0] exp_res);
        int n;
        cur_req = req;
        op_no = 0;
        rd_no = 0;
        if (nops > 0) push_op(0, wake_bytes(khz));
        if (nops > 1) push_op(3, 4);
        if (nops > 2) push_op(1, flen);
        if (nops > 3) push_op(3, rlen);
        if (nops > 4) push_op(2, 1);
        @(negedge clk);
        bus_khz   = 11'(khz);
        frame_len = 8'(flen);
        exec_ms   = 11'(ems);
        resp_len  = 8'(rlen);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
        n = 1;
        while (!done) begin
            @(negedge clk);
            n++;
        end
        chk(result == exp_res, req, "result", result, exp_res);
        chk(busy == 1'b0, "R11", "busy at done", busy, 0);
        if (nops == 0) chk(n == 2, req, "cycles start to done", n, 2);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done width", done, 0);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, req, "missing bus ops", expq.size(), 0);
        expq.delete();
        if (nops > 1 && err_op != 1) begin
            n = t_start[1] - t_done[0];
            chk(n >= WAKEMS * TICK && n <= WAKEMS * TICK + 6, "R5", "wake wait", n, WAKEMS * TICK);
        end
        if (nops > 3 && err_op != 3) begin
            n = t_start[3] - t_done[2];
            chk(n >= ems * TICK && n <= ems * TICK + 6, "R5", "exec wait", n, ems * TICK);
        end
        err_op = -1;
        st_b0 = 8'd4;  st_b1 = 8'h11;
        rs_b0 = 8'd35; rs_b1 = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(busy == 1'b0,      "R12", "busy", busy, 0);
        chk(done == 1'b0,      "R12", "done", done, 0);
        chk(bus_start == 1'b0, "R12", "bus_start", bus_start, 0);
        chk(result == 8'h00,   "R12", "result", result, 0);

        // R1 full sequence, R2 wake length at 100 kHz
        run_txn("R1", 100, 7, 2, 35, 5, 8'h00);
        run_txn("R2", 400, 9, 0, 12, 5, 8'h00);
        // R4 wake write error ignored, R2 at 1000 kHz
        err_op = 0;
        run_txn("R4", 1000, 7, 1, 35, 5, 8'h00);
        // R3 rate refused
        run_txn("R3", 1001, 7, 1, 35, 0, 8'hB1);
        run_txn("R3", 0, 7, 1, 35, 0, 8'hB1);
        // R7 wake status fault
        st_b1 = 8'h0F;
        run_txn("R7", 100, 7, 1, 35, 2, 8'h0F);
        // R6 unlisted code and wrong length byte are not faults
        st_b1 = 8'h42;
        run_txn("R6", 100, 7, 1, 35, 5, 8'h00);
        st_b0 = 8'd3; st_b1 = 8'h0F;
        run_txn("R6", 100, 7, 1, 35, 5, 8'h00);
        rs_b0 = 8'd4; rs_b1 = 8'h11;
        run_txn("R6", 100, 7, 1, 4, 5, 8'h00);
        // R8 response fault, sleep still sent
        rs_b0 = 8'd4; rs_b1 = 8'h03;
        run_txn("R8", 100, 7, 1, 4, 5, 8'h03);
        rs_b0 = 8'd4; rs_b1 = 8'hEE;
        run_txn("R8", 400, 7, 0, 4, 5, 8'hEE);
        // R9 bus errors abort
        err_op = 1; run_txn("R9", 100, 7, 1, 35, 2, 8'hB0);
        err_op = 2; run_txn("R9", 100, 7, 1, 35, 3, 8'hB0);
        err_op = 3; run_txn("R9", 100, 7, 1, 35, 4, 8'hB0);
        err_op = 4; run_txn("R9", 100, 7, 1, 35, 5, 8'hB0);
        // R10 watchdog budget
        run_txn("R10", 100, 7, 19, 35, 0, 8'hB2);
        run_txn("R10", 100, 7, 18, 35, 5, 8'h00);
        // R11 start while busy has no effect
        fork
            run_txn("R11", 100, 7, 2, 35, 5, 8'h00);
            begin
                repeat (40) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        // next request after a fault starts clean (R1)
        run_txn("R1", 100, 5, 0, 35, 5, 8'h00);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule